// File: doc/BRIEF.md
# Tagged Register Stack Unit

This block keeps the eight data registers of a floating-point datapath and presents them as a downward-growing stack. A 3-bit pointer names the register currently on top. Each register also carries a 2-bit state tag, so a consumer can tell an empty slot from a holding one, and a zero from a non-zero value, without looking at the stored bits. Arithmetic and format handling sit outside. This unit only stores values, tracks their state and reports stack misuse.

One command is issued per clock on `op_i`. Push and pop move the pointer. Read, write and free work on a register chosen as an offset from the current top. The pointer and the packed tag word are always visible. Read data and the two misuse flags are registered and hold the result of the command from the previous clock. The payload width is a parameter.

Top module: `tagged_reg_stack`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `top_o` is 0, `tag_word_o` is 16'hFFFF (every tag empty), `rdata_o` is 0, and both flags are low.
- R2: Command code 1 (push) succeeds when the register at (top-1) mod 8 is empty. On success, top becomes that index, the register takes `wdata_i`, and its tag is set by R8. The tag of register k sits in `tag_word_o[2k+1:2k]`.
- R3: A push whose target register is not empty (tag other than 11) raises `ovf_o` for one cycle. Top, the tags and the stored data stay unchanged.
- R4: Command code 2 (pop) on a non-empty top register puts its value on `rdata_o`, marks its tag 11 (empty), and advances top by one, mod 8.
- R5: A pop on an empty top register raises `unf_o` and drives `rdata_o` to 0. Top and the tags stay unchanged.
- R6: Command code 3 (read) with offset `off_i` reads register (top+off) mod 8 onto `rdata_o` and moves nothing. If that register is empty, it raises `unf_o` and drives `rdata_o` to 0.
- R7: Command code 4 (write) stores `wdata_i` into register (top+off) mod 8 whatever its tag, sets the tag by R8, and leaves top unchanged.
- R8: A stored value is tagged 10 (special) when `wspecial_i` is high. Otherwise it is tagged 01 when it is all zero, and 00 when it is not.
- R9: Command code 5 (free) marks register (top+off) mod 8 empty (11) without moving top or changing `rdata_o`.
- R10: Codes 0, 6 and 7 are idle. Top, the tags and `rdata_o` hold, and both flags are low in the next cycle.
- R11: `ovf_o` and `unf_o` describe only the command of the previous cycle. They are never high together, and they drop when the next command does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Command code: 0 idle, 1 push, 2 pop, 3 read, 4 write, 5 free |
| off_i | input | 3 | Register offset from top for read, write and free |
| wdata_i | input | DATA_W | Payload for push and write |
| wspecial_i | input | 1 | Tags the written payload as special |
| top_o | output | 3 | Current top-of-stack register index |
| tag_word_o | output | 16 | Packed tags, register k at bits 2k+1:2k |
| rdata_o | output | DATA_W | Value from the last successful pop or read |
| ovf_o | output | 1 | Push hit a non-empty register last cycle |
| unf_o | output | 1 | Pop or read hit an empty register last cycle |

## Verification
The assertions check on every cycle how the pointer and tag word must move after each command: the pointer step on a good push or pop, the frozen state on overflow, underflow and idle codes, the freed slot turning empty, and that the two flags never rise together. The stored payloads cannot be seen through a single-cycle property. The bench's scenarios show that a value pushed or written reaches the right physical register: full fills with pointer wraparound, reads at all eight offsets, overwrites of full slots, and a long pseudo-random command stream checked against an independent model of the stack.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int NREG  = 8;
    localparam int PTR_W = $clog2(NREG);
    localparam int TAG_W = 2;
    localparam int TWD_W = NREG * TAG_W;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_READ  = 3'd3,
        OP_WRITE = 3'd4,
        OP_FREE  = 3'd5
    } op_e;

    typedef enum logic [TAG_W-1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef logic [PTR_W-1:0] idx_t;

    typedef struct packed {
        logic data_we;
        idx_t data_idx;
        logic tag_we;
        idx_t tag_idx;
        logic tag_clear;
        logic top_we;
        idx_t top_nxt;
        logic rd_load;
        logic rd_clear;
        idx_t rd_idx;
        logic ovf;
        logic unf;
    } ctl_t;

    function automatic idx_t rel_idx(input idx_t top, input idx_t off);
        return idx_t'(top + off);
    endfunction

    function automatic tag_e classify(input logic is_zero, input logic special);
        if (special)      return TAG_SPECIAL;
        else if (is_zero) return TAG_ZERO;
        else              return TAG_VALID;
    endfunction

    function automatic tag_e tag_of(input logic [TWD_W-1:0] tw, input idx_t i);
        return tag_e'(tw[{i, 1'b0} +: TAG_W]);
    endfunction

endpackage

// File: rtl/trs_ctrl.sv
module trs_ctrl
    import trs_pkg::*;
(
    input  logic [2:0]       op,
    input  idx_t             off,
    input  idx_t             top,
    input  logic [TWD_W-1:0] tags,
    output ctl_t             ctl
);
    idx_t push_idx;
    idx_t pop_idx;
    idx_t off_idx;

    always_comb begin
        push_idx = idx_t'(top - 1'b1);
        pop_idx  = idx_t'(top + 1'b1);
        off_idx  = rel_idx(top, off);
        ctl      = '0;
        unique case (op)
            OP_PUSH: begin
                if (tag_of(tags, push_idx) != TAG_EMPTY) begin
                    ctl.ovf = 1'b1;
                end else begin
                    ctl.data_we  = 1'b1;
                    ctl.data_idx = push_idx;
                    ctl.tag_we   = 1'b1;
                    ctl.tag_idx  = push_idx;
                    ctl.top_we   = 1'b1;
                    ctl.top_nxt  = push_idx;
                end
            end
            OP_POP: begin
                if (tag_of(tags, top) == TAG_EMPTY) begin
                    ctl.unf      = 1'b1;
                    ctl.rd_clear = 1'b1;
                end else begin
                    ctl.rd_load   = 1'b1;
                    ctl.rd_idx    = top;
                    ctl.tag_we    = 1'b1;
                    ctl.tag_idx   = top;
                    ctl.tag_clear = 1'b1;
                    ctl.top_we    = 1'b1;
                    ctl.top_nxt   = pop_idx;
                end
            end
            OP_READ: begin
                if (tag_of(tags, off_idx) == TAG_EMPTY) begin
                    ctl.unf      = 1'b1;
                    ctl.rd_clear = 1'b1;
                end else begin
                    ctl.rd_load = 1'b1;
                    ctl.rd_idx  = off_idx;
                end
            end
            OP_WRITE: begin
                ctl.data_we  = 1'b1;
                ctl.data_idx = off_idx;
                ctl.tag_we   = 1'b1;
                ctl.tag_idx  = off_idx;
            end
            OP_FREE: begin
                ctl.tag_we    = 1'b1;
                ctl.tag_idx   = off_idx;
                ctl.tag_clear = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/trs_tag_file.sv
module trs_tag_file
    import trs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  idx_t             idx,
    input  logic             clear,
    input  logic             is_zero,
    input  logic             special,
    output logic [TWD_W-1:0] tags
);
    tag_e new_tag;

    always_comb begin
        new_tag = clear ? TAG_EMPTY : classify(is_zero, special);
    end

    for (genvar k = 0; k < NREG; k++) begin : g_tag
        tag_e q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= TAG_EMPTY;
            end else if (we && idx == idx_t'(k)) begin
                q <= new_tag;
            end
        end
        assign tags[k*TAG_W +: TAG_W] = q;
    end

endmodule

// File: rtl/trs_data_file.sv
module trs_data_file
    import trs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  idx_t              wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  idx_t              rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NREG-1:0][DATA_W-1:0] cells;

    for (genvar k = 0; k < NREG; k++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && wr_idx == idx_t'(k)) begin
                q <= wr_data;
            end
        end
        assign cells[k] = q;
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/tagged_reg_stack.sv
module tagged_reg_stack
    import trs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_i,
    input  logic [2:0]        off_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wspecial_i,
    output logic [2:0]        top_o,
    output logic [15:0]       tag_word_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ovf_o,
    output logic              unf_o
);
    ctl_t              ctl;
    idx_t              top_q;
    logic [TWD_W-1:0]  tags;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              ovf_q;
    logic              unf_q;

    trs_ctrl u_ctrl (
        .op   (op_i),
        .off  (idx_t'(off_i)),
        .top  (top_q),
        .tags (tags),
        .ctl  (ctl)
    );

    trs_tag_file u_tags (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.tag_we),
        .idx     (ctl.tag_idx),
        .clear   (ctl.tag_clear),
        .is_zero (~|wdata_i),
        .special (wspecial_i),
        .tags    (tags)
    );

    trs_data_file #(.DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.data_we),
        .wr_idx  (ctl.data_idx),
        .wr_data (wdata_i),
        .rd_idx  (ctl.rd_idx),
        .rd_data (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q   <= '0;
            rdata_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            if (ctl.top_we) begin
                top_q <= ctl.top_nxt;
            end
            if (ctl.rd_load) begin
                rdata_q <= rd_word;
            end else if (ctl.rd_clear) begin
                rdata_q <= '0;
            end
            ovf_q <= ctl.ovf;
            unf_q <= ctl.unf;
        end
    end

    assign top_o      = top_q;
    assign tag_word_o = tags;
    assign rdata_o    = rdata_q;
    assign ovf_o      = ovf_q;
    assign unf_o      = unf_q;

endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_i,
    input logic [2:0]        off_i,
    input logic [2:0]        top_o,
    input logic [15:0]       tag_word_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              ovf_o,
    input logic              unf_o
);
    function automatic logic [1:0] tg(input logic [15:0] tw, input logic [2:0] i);
        return tw[{i, 1'b0} +: 2];
    endfunction

    logic [2:0] below;
    assign below = 3'(top_o - 3'd1);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (top_o == 3'd0 && tag_word_o == 16'hFFFF && rdata_o == '0 && !ovf_o && !unf_o));

    a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1 && tg(tag_word_o, below) == 2'b11)
        |=> (top_o == 3'($past(top_o) - 3'd1) && tg(tag_word_o, top_o) != 2'b11 && !ovf_o));

    a_r3_push_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1 && tg(tag_word_o, below) != 2'b11)
        |=> (ovf_o && $stable(top_o) && $stable(tag_word_o)));

    a_r4_pop_step: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2 && tg(tag_word_o, top_o) != 2'b11)
        |=> (top_o == 3'($past(top_o) + 3'd1) && tg(tag_word_o, $past(top_o)) == 2'b11 && !unf_o));

    a_r5_pop_underflow: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2 && tg(tag_word_o, top_o) == 2'b11)
        |=> (unf_o && rdata_o == '0 && $stable(top_o) && $stable(tag_word_o)));

    a_r9_free_slot: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5)
        |=> ($stable(top_o) && $stable(rdata_o)
             && tg(tag_word_o, 3'($past(top_o) + $past(off_i))) == 2'b11));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i > 3'd5)
        |=> ($stable(top_o) && $stable(tag_word_o) && $stable(rdata_o) && !ovf_o && !unf_o));

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));

endmodule

bind tagged_reg_stack trs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .off_i      (off_i),
    .top_o      (top_o),
    .tag_word_o (tag_word_o),
    .rdata_o    (rdata_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
);

// File: tb/tagged_reg_stack_bench.sv
module tagged_reg_stack_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op_i = '0;
    logic [2:0]    off_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic          wspecial_i = 1'b0;
    logic [2:0]    top_o;
    logic [15:0]   tag_word_o;
    logic [DW-1:0] rdata_o;
    logic          ovf_o;
    logic          unf_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int            m_top;
    int            m_tag [8];
    logic [DW-1:0] m_dat [8];
    logic [DW-1:0] m_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_reg_stack #(.DATA_W(DW)) u_tagged_reg_stack (
        .clk(clk), .rst(rst), .op_i(op_i), .off_i(off_i), .wdata_i(wdata_i),
        .wspecial_i(wspecial_i), .top_o(top_o), .tag_word_o(tag_word_o),
        .rdata_o(rdata_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_tw();
        int tw = 0;
        for (int k = 0; k < 8; k++) tw |= (m_tag[k] << (2*k));
        return tw;
    endfunction

    // One command: drive after a falling edge, let one rising edge act, check at the next falling edge.
    task automatic apply(input int op, input int off, input logic [DW-1:0] d, input bit sp);
        int rel, pi, cls, e_ovf, e_unf;
        string req, treq;
        op_i = 3'(op); off_i = 3'(off); wdata_i = d; wspecial_i = sp;
        rel = (m_top + off) % 8;
        pi  = (m_top + 7) % 8;
        cls = sp ? 2 : ((d == '0) ? 1 : 0);   // R8 encoding
        e_ovf = 0; e_unf = 0;
        req = "R10"; treq = "R10";
        case (op)
            1: begin
                if (m_tag[pi] != 3) begin e_ovf = 1; req = "R3"; treq = "R3"; end
                else begin m_top = pi; m_dat[pi] = d; m_tag[pi] = cls; req = "R2"; treq = "R8"; end
            end
            2: begin
                if (m_tag[m_top] == 3) begin e_unf = 1; m_rd = '0; req = "R5"; treq = "R5"; end
                else begin m_rd = m_dat[m_top]; m_tag[m_top] = 3; m_top = (m_top + 1) % 8; req = "R4"; treq = "R4"; end
            end
            3: begin
                req = "R6"; treq = "R6";
                if (m_tag[rel] == 3) begin e_unf = 1; m_rd = '0; end
                else m_rd = m_dat[rel];
            end
            4: begin m_dat[rel] = d; m_tag[rel] = cls; req = "R7"; treq = "R8"; end
            5: begin m_tag[rel] = 3; req = "R9"; treq = "R9"; end
            default: ;
        endcase
        @(negedge clk);
        chk(req,  "top",   int'(top_o), m_top);
        chk(treq, "tags",  int'(tag_word_o), model_tw());
        chk(req,  "rdata", int'(rdata_o), int'(m_rd));
        chk((op == 1) ? "R3" : "R11", "ovf", int'(ovf_o), e_ovf);
        chk((op == 2 || op == 3) ? req : "R11", "unf", int'(unf_o), e_unf);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        m_top = 0; m_rd = '0;
        for (int k = 0; k < 8; k++) begin m_tag[k] = 3; m_dat[k] = '0; end
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk("R1", "top", int'(top_o), 0);
        chk("R1", "tags", int'(tag_word_o), 16'hFFFF);
        chk("R1", "rdata", int'(rdata_o), 0);
        chk("R1", "flags", int'({ovf_o, unf_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "tags after release", int'(tag_word_o), 16'hFFFF);

        // R2/R8: fill all eight slots, pointer wraps 0 -> 7 -> ... -> 0
        for (int k = 0; k < 8; k++)
            apply(1, 0, (k == 2) ? 16'h0 : DW'(16'h1000 + k * 17), k == 5);
        apply(1, 0, 16'hBEEF, 1'b0);                          // R3 overflow
        for (int k = 0; k < 8; k++) apply(3, k, '0, 1'b0);   // R6 every offset
        apply(4, 1, 16'h0, 1'b0);                             // R7/R8 zero
        apply(4, 2, 16'h55AA, 1'b1);                          // R7/R8 special
        apply(4, 4, 16'h0001, 1'b0);                          // R7/R8 valid
        apply(5, 6, '0, 1'b0);                                // R9
        apply(3, 6, '0, 1'b0);                                // R6 read of freed slot
        apply(0, 3, 16'h7777, 1'b0);                          // R10 idle codes
        apply(6, 1, 16'h7777, 1'b1);
        apply(7, 2, 16'h7777, 1'b0);
        for (int k = 0; k < 9; k++) apply(2, 0, '0, 1'b0);   // R4/R5 drain
        for (int k = 0; k < 8; k++) apply(5, k, '0, 1'b0);   // R9 all
        apply(2, 0, '0, 1'b0);                                // R5 empty stack
        apply(1, 0, 16'h4321, 1'b0);                          // R2 after clear

        // Pseudo-random sweep over every code, offset and tag class
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 6000; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            apply(int'(lf[2:0]), int'(lf[5:3]),
                  (lf[9:7] == 3'd0) ? '0 : lf[31:16], lf[12:10] == 3'd0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule